// File: doc/BRIEF.md
# Gated-Operand Ripple Adder ALU

This block is the only arithmetic unit of a small accumulator processor. It is a word-wide, purely combinational adder assembled from a chain of one-bit full-adder slices. Each slice conditions its operand bits before adding them. There is no result multiplexer. Every operation comes from three choices: keep operand A or force it to zero, pass or invert operand B (or force it to zero), and pick the carry fed into the lowest slice.

A 3-bit function code drives a small decoder. The decoder produces a struct of four strobes: A-enable, B-invert, B-enable and carry-in. These strobes steer the datapath. The processor selects subtraction for compare and subtract work. It uses pass-B to load a value, increment-B to advance the program address, and zero while it is held in reset.

Top module: `gated_adder_alu`

## Requirements
- R1: Function code 0 (add) gives result = (A + B) mod 2^WIDTH and carryOut = bit WIDTH of the full sum.
- R2: Function code 1 (subtract) gives result = (A + ~B + 1) mod 2^WIDTH and carryOut = 1 exactly when A >= B as unsigned numbers.
- R3: Function code 2 (pass B) gives result = B and carryOut = 0.
- R4: Function code 3 (increment B) gives result = (B + 1) mod 2^WIDTH and carryOut = 1 only when B is all ones.
- R5: Function code 4 (zero) gives result = 0 and carryOut = 0 for every A and B. This is the value the processor drives while it is in reset.
- R6: The unused function codes 5, 6 and 7 behave exactly like code 4.
- R7: Carries ripple from each slice into the next higher one, and the carry out of the top slice appears on carryOut. WIDTH is a parameter with a default of 16.
- R8: For codes 2 through 7, operand A has no effect on result or carryOut.
- R9: The block holds no state. Outputs follow a change of inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand (accumulator side) |
| opB | input | WIDTH | Second operand (memory / address side) |
| funcSel | input | 3 | Function code: 0 add, 1 subtract, 2 pass B, 3 increment B, 4..7 zero |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the most significant slice |

## Verification
The bench goes after long carry chains. All-ones plus one must wrap to zero with carryOut set. A slice that dropped its carry-in link would instead leave ones scattered in the result. For subtraction it probes A equal to B, A one below B, and zero minus one, where a wrong carry polarity or a missing inverted-B shows up as an off-by-one or a flipped borrow.

For pass-B, increment-B and zero it varies A while holding everything else fixed. An A-enable that leaks would change the result. For the unused codes it compares against code 4, so a decoder that fell through to add would be caught.

// File: rtl/gated_alu_pkg.sv
package gated_alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD    = 3'd0,
    FN_SUB    = 3'd1,
    FN_PASS_B = 3'd2,
    FN_INC_B  = 3'd3,
    FN_ZERO   = 3'd4
  } aluFunc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic aEnable;  // 1: use A, 0: force A to zero
    logic bInvert;  // 1: invert B before the adder
    logic bEnable;  // 1: use (possibly inverted) B, 0: force to zero
    logic carryIn;  // carry into the lowest slice
  } aluCtrl_t;

endpackage

// File: rtl/gated_alu_ctrl.sv
module gated_alu_ctrl
  import gated_alu_pkg::*;
(
  input  logic [2:0] funcSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{aEnable: 1'b0, bInvert: 1'b0, bEnable: 1'b0, carryIn: 1'b0};
    case (funcSel)
      FN_ADD:    ctrl = '{aEnable: 1'b1, bInvert: 1'b0, bEnable: 1'b1, carryIn: 1'b0};
      FN_SUB:    ctrl = '{aEnable: 1'b1, bInvert: 1'b1, bEnable: 1'b1, carryIn: 1'b1};
      FN_PASS_B: ctrl = '{aEnable: 1'b0, bInvert: 1'b0, bEnable: 1'b1, carryIn: 1'b0};
      FN_INC_B:  ctrl = '{aEnable: 1'b0, bInvert: 1'b0, bEnable: 1'b1, carryIn: 1'b1};
      default:   ctrl = '{aEnable: 1'b0, bInvert: 1'b0, bEnable: 1'b0, carryIn: 1'b0};
    endcase
  end

  // A must be gated off for every code above subtract
  always_comb begin
    if (!$isunknown(funcSel) && funcSel > 3'd1)
      AST_A_GATED_OFF: assert final (!ctrl.aEnable); // R8
  end

  // Inverting B is only meaningful together with the +1 carry
  always_comb begin
    if (!$isunknown(funcSel) && ctrl.bInvert)
      AST_INVERT_WITH_CARRY: assert final (ctrl.carryIn && ctrl.aEnable); // R2
  end

  // When B is gated off nothing else may contribute to the sum
  always_comb begin
    if (!$isunknown(funcSel) && !ctrl.bEnable)
      AST_ZERO_ALL_OFF: assert final (!ctrl.aEnable && !ctrl.carryIn); // R5
  end

endmodule

// File: rtl/gated_alu_slice.sv
module gated_alu_slice
  import gated_alu_pkg::*;
(
  input  logic     aBit,
  input  logic     bBit,
  input  aluCtrl_t ctrl,
  input  logic     cin,
  output logic     sum,
  output logic     cout
);

  logic gatedA;
  logic gatedB;

  always_comb begin
    gatedA = aBit & ctrl.aEnable;
    gatedB = (bBit ^ ctrl.bInvert) & ctrl.bEnable;
    sum    = gatedA ^ gatedB ^ cin;
    cout   = (gatedA & gatedB) | (cin & (gatedA ^ gatedB));
  end

endmodule

// File: rtl/gated_alu_path.sv
module gated_alu_path
  import gated_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] sumWord,
  output logic             carryTop
);

  localparam int CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] carryChain;

  assign carryChain[0] = ctrl.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    gated_alu_slice u_slice (
      .aBit (opA[i]),
      .bBit (opB[i]),
      .ctrl (ctrl),
      .cin  (carryChain[i]),
      .sum  (sumWord[i]),
      .cout (carryChain[i+1])
    );
  end

  assign carryTop = carryChain[WIDTH];

  // Cross-check the bit-level ripple against word arithmetic
  logic [WIDTH-1:0] refA;
  logic [WIDTH-1:0] refB;
  logic [WIDTH:0]   refSum;

  always_comb begin
    refA   = ctrl.aEnable ? opA : '0;
    refB   = ctrl.bEnable ? (ctrl.bInvert ? ~opB : opB) : '0;
    refSum = {1'b0, refA} + {1'b0, refB} + {{WIDTH{1'b0}}, ctrl.carryIn};
  end

  always_comb begin
    if (!$isunknown({opA, opB, ctrl}))
      AST_RIPPLE_MATCHES: assert final ({carryTop, sumWord} == refSum); // R7
  end

endmodule

// File: rtl/gated_adder_alu.sv
module gated_adder_alu
  import gated_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funcSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluCtrl_t aluCtrl;

  gated_alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .ctrl    (aluCtrl)
  );

  gated_alu_path #(.WIDTH(WIDTH)) u_path (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (aluCtrl),
    .sumWord  (result),
    .carryTop (carryOut)
  );

  always_comb begin
    if (!$isunknown({opA, opB, funcSel}) && funcSel == 3'd2)
      AST_PASS_B_OUT: assert final (result == opB && !carryOut); // R3
  end

  always_comb begin
    if (!$isunknown({opA, opB, funcSel}) && funcSel == 3'd3)
      AST_INC_B_CARRY: assert final (carryOut == (&opB)); // R4
  end

  always_comb begin
    if (!$isunknown(funcSel) && funcSel >= 3'd4)
      AST_ZERO_OUT: assert final (result == '0 && !carryOut); // R6
  end

endmodule

// File: tb/gated_adder_alu_test.sv
`timescale 1ns/1ps
module gated_adder_alu_test;

  localparam int W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA;
  logic [W-1:0] opB;
  logic [2:0]   funcSel;
  logic [W-1:0] result;
  logic         carryOut;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  gated_adder_alu #(.WIDTH(W)) uut (
    .opA      (opA),
    .opB      (opB),
    .funcSel  (funcSel),
    .result   (result),
    .carryOut (carryOut)
  );

  task automatic expectOut(input string tag, input logic [W-1:0] expR, input logic expC);
    compared++;
    if (result !== expR || carryOut !== expC) begin
      mismatched++;
      $display("FAIL %s: A=%h B=%h f=%0d got res=%h c=%b expected res=%h c=%b",
               tag, opA, opB, funcSel, result, carryOut, expR, expC);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    @(posedge clk);
    opA = a; opB = b; funcSel = f;
    @(negedge clk);
  endtask

  // Reset-time output: zero code
  task automatic testResetZero();
    apply(16'h1234, 16'hABCD, 3'd4);
    expectOut("R5 reset zero", '0, 1'b0);
  endtask

  task automatic testAdd();
    logic [W:0] full;
    logic [W-1:0] av [4] = '{16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [W-1:0] bv [4] = '{16'h0002, 16'h0001, 16'h8000, 16'h0001};
    for (int i = 0; i < 4; i++) begin
      apply(av[i], bv[i], 3'd0);
      full = {1'b0, av[i]} + {1'b0, bv[i]};
      expectOut("R1 add", full[W-1:0], full[W]);
    end
    // Full-length carry ripple
    apply(ONES, 16'h0001, 3'd0);
    expectOut("R7 ripple wrap", '0, 1'b1);
  endtask

  task automatic testSub();
    logic [W-1:0] av [4] = '{16'h0050, 16'h0050, 16'h004F, 16'h0000};
    logic [W-1:0] bv [4] = '{16'h0020, 16'h0050, 16'h0050, 16'h0001};
    for (int i = 0; i < 4; i++) begin
      apply(av[i], bv[i], 3'd1);
      expectOut("R2 sub", av[i] - bv[i], (av[i] >= bv[i]) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic testPassB();
    apply(16'h0000, 16'hBEEF, 3'd2);
    expectOut("R3 passB", 16'hBEEF, 1'b0);
    apply(16'hFFFF, 16'hBEEF, 3'd2);
    expectOut("R8 passB ignores A", 16'hBEEF, 1'b0);
  endtask

  task automatic testIncB();
    apply(16'h0000, 16'h00FF, 3'd3);
    expectOut("R4 incB", 16'h0100, 1'b0);
    apply(16'h5A5A, 16'h00FF, 3'd3);
    expectOut("R8 incB ignores A", 16'h0100, 1'b0);
    apply(16'h0000, ONES, 3'd3);
    expectOut("R4 incB wrap", '0, 1'b1);
  endtask

  task automatic testZeroAndUnused();
    apply(ONES, ONES, 3'd4);
    expectOut("R5 zero all ones", '0, 1'b0);
    for (int f = 5; f < 8; f++) begin
      apply(16'hC3C3, 16'h3C3C, 3'(f));
      expectOut("R6 unused code", '0, 1'b0);
      apply(16'h0001, ONES, 3'(f));
      expectOut("R8 unused ignores A", '0, 1'b0);
    end
  endtask

  // Inputs change between edges; outputs must follow with no clock
  task automatic testCombinational();
    @(negedge clk);
    opA = 16'h0010; opB = 16'h0005; funcSel = 3'd0;
    #1;
    expectOut("R9 no clock add", 16'h0015, 1'b0);
    opB = 16'h0006;
    #1;
    expectOut("R9 no clock update", 16'h0016, 1'b0);
  endtask

  initial begin
    opA = '0; opB = '0; funcSel = 3'd4;
    repeat (2) @(posedge clk);
    testResetZero();
    testAdd();
    testSub();
    testPassB();
    testIncB();
    testZeroAndUnused();
    testCombinational();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule